// File: doc/BRIEF.md
# Decimated Result Sampler and Packer

This block sits at the end of a fixed-step numerical solver. It watches a strobe that marks the end of each solver step and counts the steps since the last sample. Once the count reaches a programmable interval, it takes one snapshot of the results. Each snapshot is a short list of 32-bit words. The first part of the list holds electrical quantities. These are picked by node number from a wide double-precision result vector and narrowed to single precision. The second part holds control quantities, which are already single precision and are taken in their natural order. A small state machine writes the list into a downstream FIFO, one word per cycle.

The node numbers that choose the electrical quantities live in a small selection table. Software fills this table while a preload phase is active, so a new study case only needs new table contents and new counts, with no change to the hardware. If the FIFO is full, the rest of the snapshot is dropped and a sticky flag is raised. The same flag is raised when a new sample arrives while the previous snapshot is still being written.

Top module: `result_sampler`

## Requirements
- R1: `sample_pulse` is high for one cycle, in the cycle after the `step_done` cycle that brings the number of completed steps since the last sample up to `cfg_interval`. The step count then restarts at zero. An interval of 0 behaves like an interval of 1, so every step samples.
- R2: While `preload` is high, `step_done` is not counted and the step count is held at zero. Selection-table writes (`sel_we`, with slot `sel_addr` and node `sel_node`) take effect only while `preload` is high. A write made while `preload` is low has no effect.
- R3: A double is narrowed to single precision with round-to-nearest, ties to even. The guard bit is double mantissa bit 28, and the sticky bits are double mantissa bits 27..0. Examples: 0x3FF0000010000000 gives 0x3F800000, 0x3FF0000030000000 gives 0x3F800002, and 0x3FF0000010000001 gives 0x3F800001.
- R4: A value whose single exponent would be 255 or more, before or after rounding, becomes a signed infinity (0x7F800000 with the sign bit). A double infinity stays infinity. A double NaN becomes a quiet NaN with the same sign (0x7FC00000 when positive).
- R5: A value whose single biased exponent would be 0 or below flushes to a signed zero. This includes double zeros and double subnormals. For example, 0x8010000000000000 gives 0x80000000.
- R6: A snapshot is written in a fixed order. First come the electrical words for table slots 0 up to ne-1, where slot k supplies the narrowed value of node `sel_node[k]`. Then come control words 0 up to nc-1, where control word j is `ctrl_results[32*j +: 32]`, and node n is `elec_results[64*n +: 64]`.
- R7: The counts are clamped when a sample is accepted. ne is the smaller of `cfg_n_elec` and MAX_OUT. nc is the smallest of `cfg_n_ctrl`, N_CTRL and MAX_OUT-ne. The word count ne+nc therefore never exceeds MAX_OUT.
- R8: Words are written on consecutive cycles, starting in the cycle after `sample_pulse`. `fifo_wr_en` is never high while `fifo_full` is high.
- R9: If `fifo_full` is high in a cycle where a snapshot word is pending, that word and all later words of the same snapshot are dropped. `overflow` is then set, and it stays set until reset.
- R10: A sample that arrives in the same cycle as the last word of the current snapshot is accepted, and its words follow with no gap. A sample that arrives earlier in a snapshot is discarded and sets `overflow`.
- R11: After reset, `sample_pulse`, `fifo_wr_en` and `overflow` are low, the step count is zero, and every table slot selects node 0.
- R12: A sample whose clamped word count is zero produces no FIFO write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| preload | input | 1 | Preload phase: table writable, step counting held |
| sel_we | input | 1 | Selection-table write strobe |
| sel_addr | input | 3 | Table slot to write |
| sel_node | input | 3 | Node number stored in the slot |
| cfg_interval | input | 16 | Steps per sample |
| cfg_n_elec | input | 3 | Requested electrical word count |
| cfg_n_ctrl | input | 3 | Requested control word count |
| step_done | input | 1 | One-cycle strobe at the end of a solver step |
| elec_results | input | 512 | Double-precision result per node |
| ctrl_results | input | 128 | Single-precision control results |
| fifo_full | input | 1 | Downstream FIFO cannot accept a word |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 32 | FIFO write word |
| sample_pulse | output | 1 | Sample decision for this cycle |
| overflow | output | 1 | Sticky flag for a dropped word or a dropped sample |

## Verification
Two events can fall in the same cycle: a new sample decision and the writing of the last word of the snapshot already in flight. To provoke this, the sampling interval is set to every step, and step strobes are placed so that one decision lands exactly on the final word of a four-word snapshot. A second decision is placed in the middle of the following snapshot. The checks are as follows. The first collision must start the next snapshot directly, with no gap and with `overflow` still low. The mid-snapshot decision must leave the word count unchanged and raise `overflow` one cycle later. A separate case raises `fifo_full` in the middle of a snapshot, which makes the drop path and the write path compete in one cycle.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int WORD_W = 32;
    localparam int DBL_W  = 64;

    typedef enum logic [0:0] {
        WR_IDLE = 1'b0,
        WR_SEND = 1'b1
    } wr_state_e;

    // Double to single: round to nearest even, saturate to infinity, flush to zero.
    function automatic logic [WORD_W-1:0] dbl_to_sgl(input logic [DBL_W-1:0] d);
        logic               sgn;
        logic [10:0]        ex;
        logic [51:0]        man;
        logic signed [12:0] be;
        logic               rnd;
        logic [30:0]        sum;
        logic [WORD_W-1:0]  res;
        sgn = d[63];
        ex  = d[62:52];
        man = d[51:0];
        be  = $signed({2'b00, ex}) - 13'sd896;
        rnd = man[28] & ((|man[27:0]) | man[29]);
        sum = {be[7:0], man[51:29]} + {30'd0, rnd};
        if (ex == 11'h7FF)
            res = (man != 52'd0) ? {sgn, 8'hFF, 1'b1, 22'd0} : {sgn, 8'hFF, 23'd0};
        else if (be <= 13'sd0)
            res = {sgn, 31'd0};
        else if (be >= 13'sd255)
            res = {sgn, 8'hFF, 23'd0};
        else
            res = {sgn, sum};
        return res;
    endfunction

endpackage

// File: rtl/rsp_step_counter.sv
module rsp_step_counter #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          preload,
    input  logic          step_done,
    input  logic [IW-1:0] interval,
    output logic          sample
);
    logic [IW-1:0] cnt_q;
    logic [IW:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + {{IW{1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst || preload) begin
            cnt_q  <= '0;
            sample <= 1'b0;
        end else begin
            sample <= 1'b0;
            if (step_done) begin
                if (cnt_inc >= {1'b0, interval}) begin
                    sample <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_inc[IW-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/rsp_select_table.sv
module rsp_select_table #(
    parameter int DEPTH = 6,
    parameter int AW    = 3,
    parameter int NW    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                preload,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [NW-1:0]       node,
    output logic [DEPTH*NW-1:0] sel_flat
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_entry
        logic [NW-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (rst)
                ent_q <= '0;
            else if (preload && we && (addr == AW'(s)))
                ent_q <= node;
        end
        assign sel_flat[s*NW +: NW] = ent_q;
    end
endmodule

// File: rtl/rsp_set_builder.sv
module rsp_set_builder #(
    parameter int N_NODE  = 8,
    parameter int N_CTRL  = 4,
    parameter int MAX_OUT = 6,
    parameter int NW      = 3,
    parameter int CW      = 3
) (
    input  logic [N_NODE*rsp_pkg::DBL_W-1:0]   elec_flat,
    input  logic [N_CTRL*rsp_pkg::WORD_W-1:0]  ctrl_flat,
    input  logic [MAX_OUT*NW-1:0]              sel_flat,
    input  logic [CW-1:0]                      ne,
    input  logic [CW-1:0]                      nc,
    output logic [MAX_OUT*rsp_pkg::WORD_W-1:0] set_flat
);
    import rsp_pkg::*;

    for (genvar k = 0; k < MAX_OUT; k++) begin : g_slot
        logic [NW-1:0]     node;
        logic [DBL_W-1:0]  dsel;
        logic [WORD_W-1:0] w;

        assign node = sel_flat[k*NW +: NW];

        always_comb begin
            dsel = '0;
            for (int n = 0; n < N_NODE; n++)
                if (node == NW'(n)) dsel = elec_flat[n*DBL_W +: DBL_W];
        end

        always_comb begin
            w = '0;
            if (int'(ne) > k)
                w = dbl_to_sgl(dsel);
            else
                for (int c = 0; c < N_CTRL; c++)
                    if ((int'(ne) + c == k) && (c < int'(nc)))
                        w = ctrl_flat[c*WORD_W +: WORD_W];
        end

        assign set_flat[k*WORD_W +: WORD_W] = w;
    end
endmodule

// File: rtl/rsp_fifo_writer.sv
module rsp_fifo_writer #(
    parameter int MAX_OUT = 6,
    parameter int CW      = 3
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               sample,
    input  logic [MAX_OUT*rsp_pkg::WORD_W-1:0] set_flat,
    input  logic [CW-1:0]                      total,
    input  logic                               fifo_full,
    output logic                               fifo_wr_en,
    output logic [rsp_pkg::WORD_W-1:0]         fifo_wr_data,
    output logic                               overflow
);
    import rsp_pkg::*;

    wr_state_e                    state_q;
    logic [CW-1:0]                ptr_q;
    logic [CW-1:0]                last_q;
    logic [MAX_OUT*WORD_W-1:0]    hold_q;
    logic                         done_now;
    logic                         accept;

    assign done_now = (state_q == WR_SEND) && !fifo_full && (ptr_q == last_q);
    assign accept   = sample && ((state_q == WR_IDLE) || done_now);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= WR_IDLE;
            ptr_q    <= '0;
            last_q   <= '0;
            hold_q   <= '0;
            overflow <= 1'b0;
        end else begin
            if (state_q == WR_SEND) begin
                if (fifo_full) begin
                    state_q  <= WR_IDLE;
                    overflow <= 1'b1;
                end else if (ptr_q == last_q) begin
                    state_q <= WR_IDLE;
                end else begin
                    ptr_q <= ptr_q + 1'b1;
                end
            end
            if (sample && !accept)
                overflow <= 1'b1;
            if (accept && (total != '0)) begin
                hold_q  <= set_flat;
                ptr_q   <= '0;
                last_q  <= total - 1'b1;
                state_q <= WR_SEND;
            end
        end
    end

    assign fifo_wr_en   = (state_q == WR_SEND) && !fifo_full;
    assign fifo_wr_data = hold_q[int'(ptr_q)*WORD_W +: WORD_W];
endmodule

// File: rtl/result_sampler.sv
module result_sampler #(
    parameter int N_NODE  = 8,
    parameter int N_CTRL  = 4,
    parameter int MAX_OUT = 6,
    parameter int IW      = 16,
    localparam int NW     = (N_NODE > 1) ? $clog2(N_NODE) : 1,
    localparam int AW     = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1,
    localparam int CW     = $clog2(MAX_OUT + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     preload,
    input  logic                     sel_we,
    input  logic [AW-1:0]            sel_addr,
    input  logic [NW-1:0]            sel_node,
    input  logic [IW-1:0]            cfg_interval,
    input  logic [CW-1:0]            cfg_n_elec,
    input  logic [CW-1:0]            cfg_n_ctrl,
    input  logic                     step_done,
    input  logic [N_NODE*64-1:0]     elec_results,
    input  logic [N_CTRL*32-1:0]     ctrl_results,
    input  logic                     fifo_full,
    output logic                     fifo_wr_en,
    output logic [31:0]              fifo_wr_data,
    output logic                     sample_pulse,
    output logic                     overflow
);
    localparam int CTRL_CAP = (N_CTRL < MAX_OUT) ? N_CTRL : MAX_OUT;

    logic [MAX_OUT*NW-1:0] sel_flat;
    logic [MAX_OUT*32-1:0] set_flat;
    logic [CW-1:0]         ne_c, room, nc_c, total;

    always_comb begin
        ne_c = (cfg_n_elec > CW'(MAX_OUT)) ? CW'(MAX_OUT) : cfg_n_elec;
        room = CW'(MAX_OUT) - ne_c;
        nc_c = cfg_n_ctrl;
        if (nc_c > CW'(CTRL_CAP)) nc_c = CW'(CTRL_CAP);
        if (nc_c > room)          nc_c = room;
        total = ne_c + nc_c;
    end

    rsp_step_counter #(.IW(IW)) u_cnt (
        .clk(clk), .rst(rst), .preload(preload), .step_done(step_done),
        .interval(cfg_interval), .sample(sample_pulse)
    );

    rsp_select_table #(.DEPTH(MAX_OUT), .AW(AW), .NW(NW)) u_tab (
        .clk(clk), .rst(rst), .preload(preload), .we(sel_we),
        .addr(sel_addr), .node(sel_node), .sel_flat(sel_flat)
    );

    rsp_set_builder #(.N_NODE(N_NODE), .N_CTRL(N_CTRL), .MAX_OUT(MAX_OUT),
                      .NW(NW), .CW(CW)) u_build (
        .elec_flat(elec_results), .ctrl_flat(ctrl_results), .sel_flat(sel_flat),
        .ne(ne_c), .nc(nc_c), .set_flat(set_flat)
    );

    rsp_fifo_writer #(.MAX_OUT(MAX_OUT), .CW(CW)) u_wr (
        .clk(clk), .rst(rst), .sample(sample_pulse), .set_flat(set_flat),
        .total(total), .fifo_full(fifo_full), .fifo_wr_en(fifo_wr_en),
        .fifo_wr_data(fifo_wr_data), .overflow(overflow)
    );
endmodule

// File: rtl/rsp_checker.sv
module rsp_checker (
    input logic clk,
    input logic rst,
    input logic preload,
    input logic step_done,
    input logic sample_pulse,
    input logic fifo_full,
    input logic fifo_wr_en,
    input logic overflow
);
    assert_sample_follows_step_R1: assert property (@(posedge clk) disable iff (rst)
        sample_pulse |-> $past(step_done));

    assert_no_sample_after_preload_R2: assert property (@(posedge clk) disable iff (rst)
        $past(preload) |-> !sample_pulse);

    assert_no_write_when_full_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_en |-> !fifo_full);

    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_overflow_has_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> ($past(fifo_full) || $past(sample_pulse)));
endmodule

bind result_sampler rsp_checker u_chk (
    .clk(clk), .rst(rst), .preload(preload), .step_done(step_done),
    .sample_pulse(sample_pulse), .fifo_full(fifo_full),
    .fifo_wr_en(fifo_wr_en), .overflow(overflow)
);

// File: tb/result_sampler_tb.sv
module result_sampler_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         preload;
    logic         sel_we;
    logic [2:0]   sel_addr;
    logic [2:0]   sel_node;
    logic [15:0]  cfg_interval;
    logic [2:0]   cfg_n_elec;
    logic [2:0]   cfg_n_ctrl;
    logic         step_done;
    logic [511:0] elec_results;
    logic [127:0] ctrl_results;
    logic         fifo_full;
    logic         fifo_wr_en;
    logic [31:0]  fifo_wr_data;
    logic         sample_pulse;
    logic         overflow;

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [31:0] got [16];
    int          ngot;
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    result_sampler u_dut (
        .clk(clk), .rst(rst), .preload(preload), .sel_we(sel_we),
        .sel_addr(sel_addr), .sel_node(sel_node), .cfg_interval(cfg_interval),
        .cfg_n_elec(cfg_n_elec), .cfg_n_ctrl(cfg_n_ctrl), .step_done(step_done),
        .elec_results(elec_results), .ctrl_results(ctrl_results),
        .fifo_full(fifo_full), .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .sample_pulse(sample_pulse), .overflow(overflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; preload = 1'b0; sel_we = 1'b0; sel_addr = '0; sel_node = '0;
        step_done = 1'b0; fifo_full = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_table(input logic [2:0] nodes [6]);
        @(negedge clk);
        preload = 1'b1;
        for (int s = 0; s < 6; s++) begin
            sel_we = 1'b1; sel_addr = 3'(s); sel_node = nodes[s];
            @(negedge clk);
        end
        sel_we = 1'b0; preload = 1'b0;
        @(negedge clk);
    endtask

    task automatic step();
        @(negedge clk) step_done = 1'b1;
        @(negedge clk) step_done = 1'b0;
    endtask

    task automatic collect();
        ngot = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (fifo_wr_en) begin
                got[ngot] = fifo_wr_data;
                ngot++;
            end
        end
    endtask

    task automatic sample_and_check(input string req, input int n, input logic [31:0] exp [6]);
        step();
        check({req, " sample pulse"}, 32'(sample_pulse), 32'd1);
        collect();
        check({req, " word count"}, 32'(ngot), 32'(n));
        for (int i = 0; i < n && i < ngot; i++)
            check({req, " word"}, got[i], exp[i]);
    endtask

    task automatic t_reset_state();
        check("R11 sample_pulse", 32'(sample_pulse), 32'd0);
        check("R11 fifo_wr_en", 32'(fifo_wr_en), 32'd0);
        check("R11 overflow", 32'(overflow), 32'd0);
        cfg_interval = 16'd1; cfg_n_elec = 3'd1; cfg_n_ctrl = 3'd0;
        sample_and_check("R11 table slot0 selects node0", 1,
            '{32'h3F800000, 0, 0, 0, 0, 0});
    endtask

    task automatic t_merge_round();
        load_table('{3'd3, 3'd0, 3'd7, 3'd1, 3'd0, 3'd0});
        cfg_n_elec = 3'd4; cfg_n_ctrl = 3'd2;
        sample_and_check("R6 R3 R4 merge order and rounding", 6,
            '{32'h3F800002, 32'h3F800000, 32'h7FC00000, 32'hC0000000,
              32'hC0DE0000, 32'hC0DE0011});
    endtask

    task automatic t_clamp_overflow_inf();
        elec_results[0*64 +: 64] = 64'h47EFFFFFF0000000;
        load_table('{3'd2, 3'd4, 3'd5, 3'd6, 3'd0, 3'd3});
        cfg_n_elec = 3'd6; cfg_n_ctrl = 3'd2;
        sample_and_check("R7 R3 R4 R5 full elec set, ctrl clamped", 6,
            '{32'h3F800000, 32'h3F800001, 32'h7F800000, 32'h80000000,
              32'h7F800000, 32'h3F800002});
        cfg_n_elec = 3'd1; cfg_n_ctrl = 3'd7;
        sample_and_check("R7 ctrl clamped to N_CTRL", 5,
            '{32'h3F800000, 32'hC0DE0000, 32'hC0DE0011, 32'h12345678, 32'h0BADF00D, 0});
    endtask

    task automatic t_ignored_write();
        @(negedge clk);
        sel_we = 1'b1; sel_addr = 3'd0; sel_node = 3'd5;
        @(negedge clk);
        sel_we = 1'b0;
        cfg_n_elec = 3'd1; cfg_n_ctrl = 3'd0;
        sample_and_check("R2 write outside preload ignored", 1,
            '{32'h3F800000, 0, 0, 0, 0, 0});
    endtask

    task automatic t_zero_and_interval();
        cfg_n_elec = 3'd0; cfg_n_ctrl = 3'd0;
        step();
        check("R12 pulse with empty set", 32'(sample_pulse), 32'd1);
        collect();
        check("R12 no write for empty set", 32'(ngot), 32'd0);
        cfg_interval = 16'd3;
        for (int r = 0; r < 2; r++) begin
            step(); check("R1 no pulse step 1", 32'(sample_pulse), 32'd0);
            step(); check("R1 no pulse step 2", 32'(sample_pulse), 32'd0);
            step(); check("R1 pulse on step 3", 32'(sample_pulse), 32'd1);
            @(negedge clk);
            check("R1 pulse lasts one cycle", 32'(sample_pulse), 32'd0);
        end
        cfg_interval = 16'd0;
        step(); check("R1 interval 0 samples each step", 32'(sample_pulse), 32'd1);
        step(); check("R1 interval 0 samples each step", 32'(sample_pulse), 32'd1);
    endtask

    task automatic t_preload_hold();
        cfg_interval = 16'd2;
        step(); check("R2 first step no pulse", 32'(sample_pulse), 32'd0);
        @(negedge clk) begin preload = 1'b1; step_done = 1'b1; end
        @(negedge clk) begin preload = 1'b0; step_done = 1'b0; end
        check("R2 step during preload ignored", 32'(sample_pulse), 32'd0);
        step(); check("R2 count cleared by preload", 32'(sample_pulse), 32'd0);
        step(); check("R2 count resumes from zero", 32'(sample_pulse), 32'd1);
    endtask

    task automatic t_fifo_full();
        do_reset();
        cfg_interval = 16'd1; cfg_n_elec = 3'd0; cfg_n_ctrl = 3'd4;
        step();
        ngot = 0;
        @(negedge clk);
        check("R8 first word right after pulse", 32'(fifo_wr_en), 32'd1);
        check("R8 first word value", fifo_wr_data, 32'hC0DE0000);
        @(negedge clk);
        check("R8 second word value", fifo_wr_data, 32'hC0DE0011);
        fifo_full = 1'b1;
        #1;
        check("R8 no write while full", 32'(fifo_wr_en), 32'd0);
        @(negedge clk);
        check("R9 overflow set on drop", 32'(overflow), 32'd1);
        fifo_full = 1'b0;
        collect();
        check("R9 rest of set dropped", 32'(ngot), 32'd0);
        check("R9 overflow sticky", 32'(overflow), 32'd1);
    endtask

    task automatic t_busy_collision();
        int words;
        do_reset();
        cfg_interval = 16'd0; cfg_n_elec = 3'd0; cfg_n_ctrl = 3'd4;
        words = 0;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (fifo_wr_en) words++;
            if (i == 6) check("R10 back-to-back set starts", fifo_wr_data, 32'hC0DE0000);
            if (i == 8) check("R10 collision with last word accepted", 32'(overflow), 32'd0);
            if (i == 9) check("R10 mid-set sample rejected", 32'(overflow), 32'd1);
            step_done = (i == 0 || i == 4 || i == 7);
        end
        step_done = 1'b0;
        check("R10 total words", 32'(words), 32'd8);
    endtask

    initial begin
        elec_results = '0;
        elec_results[0*64 +: 64] = 64'h3FF0000000000000;
        elec_results[1*64 +: 64] = 64'hC000000000000000;
        elec_results[2*64 +: 64] = 64'h3FF0000010000000;
        elec_results[3*64 +: 64] = 64'h3FF0000030000000;
        elec_results[4*64 +: 64] = 64'h3FF0000010000001;
        elec_results[5*64 +: 64] = 64'h7E37E43C8800759C;
        elec_results[6*64 +: 64] = 64'h8010000000000000;
        elec_results[7*64 +: 64] = 64'h7FF8000000000000;
        ctrl_results = {32'h0BADF00D, 32'h12345678, 32'hC0DE0011, 32'hC0DE0000};
        cfg_interval = 16'd1; cfg_n_elec = '0; cfg_n_ctrl = '0;
        do_reset();
        t_reset_state();
        t_merge_round();
        t_clamp_overflow_inf();
        t_ignored_write();
        t_zero_and_interval();
        t_preload_hold();
        t_fifo_full();
        t_busy_collision();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule